// File: doc/BRIEF.md
# MESI Coherence Line State Controller

This block keeps the coherence state of every line of one private cache in a snooping multicore system. Each line is held as Modified, Exclusive, Shared or Invalid. Local read, write and evict requests come from the cache's own pipeline, and read and invalidate requests snooped from the other cores come in from the interconnect. In response the block raises bus actions (line fetch, invalidate broadcast, writeback, snoop acknowledge) and reports when a local write may proceed. It stores no data and makes no replacement choice.

A local controller with three named states sequences the local requests. CTL_IDLE accepts a request. CTL_FILL waits for a fetched line and the interconnect's "another cache has a copy" flag. CTL_INVWAIT counts invalidation acknowledgements from the other cores. Per-line transitions: read miss I->E or I->S; silent write upgrade E->M; write upgrade S->M after all acknowledgements; write miss I->M (through S->M when the fill is shared); evict M/E/S->I; snooped read M->S (with writeback) and E->S; snooped invalidate M/E/S->I. A snooped request always takes effect in the cycle it is presented. A local request is refused in any cycle that carries a snoop.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `loc_ready` is 1 and every pulse output (`op_done`, `wr_grant`, `bus_fetch`, `bus_inval`, `bus_wb`, `snp_hit`, `snp_wb`, `snp_ack`) is 0.
- R2: A local read (`loc_op`=0) of a line in M, E or S gives `op_done` in the next cycle, no bus action, and leaves the state unchanged.
- R3: A local read of an Invalid line gives `bus_fetch` with `bus_line` equal to the line in the next cycle. The cycle after `fill_done` gives `op_done`, and the line becomes E if `fill_shared` was 0 and S if it was 1.
- R4: A local write (`loc_op`=1) to a line in E or M gives `wr_grant` and `op_done` in the next cycle with no bus action, and the line ends in M.
- R5: A local write to a Shared line gives `bus_inval` in the next cycle. `wr_grant` comes only in the cycle after the `ack_in` bits collected while waiting reach NUM_PEERS in total. Acknowledgements presented while no invalidate is outstanding are ignored. The line ends in M.
- R6: A local write to an Invalid line gives `bus_fetch`. A fill with `fill_shared`=0 grants the write at once. A fill with `fill_shared`=1 continues as the Shared write of R5. Either way the line ends in M.
- R7: If a snooped invalidate hits the line whose invalidate broadcast is outstanding, completing the acknowledgements raises `bus_fetch` instead of `wr_grant`, and the write is granted only after that fill.
- R8: A local evict (`loc_op`=2) makes the line Invalid and gives `op_done`. It gives `bus_wb` only if the line was Modified.
- R9: A snooped read (`snp_kind`=0) gives `snp_hit` next cycle when the line is not Invalid, and `snp_wb` when it is Modified. M and E become S, while S and I are unchanged.
- R10: A snooped invalidate (`snp_kind`=1) always gives `snp_ack` next cycle, gives `snp_wb` when the line was Modified, and leaves the line Invalid. Other lines are not affected.
- R11: `loc_ready` is 0 while `snp_valid` is 1 or a fill or acknowledgement wait is outstanding. A local request presented then has no effect.
- R12: `loc_op`=3 is a no-operation: no `op_done`, no bus action, no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-operation |
| loc_line | input | LINE_W | Line index of the local request |
| loc_ready | output | 1 | Local request is accepted this cycle |
| op_done | output | 1 | Local request finished (pulse) |
| wr_grant | output | 1 | Local write may proceed (pulse) |
| bus_fetch | output | 1 | Request line fetch (pulse) |
| bus_inval | output | 1 | Broadcast invalidate (pulse) |
| bus_wb | output | 1 | Writeback of evicted modified line (pulse) |
| bus_line | output | LINE_W | Line index for bus_fetch, bus_inval, bus_wb |
| fill_done | input | 1 | Fetched line has arrived |
| fill_shared | input | 1 | Another cache holds a copy of the fetched line |
| ack_in | input | NUM_PEERS | Invalidation acknowledgements, one bit per peer |
| snp_valid | input | 1 | Snooped request present |
| snp_kind | input | 1 | 0 remote read, 1 invalidate |
| snp_line | input | LINE_W | Line index of the snooped request |
| snp_hit | output | 1 | Snooped line was held (pulse) |
| snp_wb | output | 1 | Forced writeback of modified data (pulse) |
| snp_ack | output | 1 | Invalidate acknowledgement (pulse) |

## Verification
On every cycle the assertions check these rules: a granted write finds its line in M, a line waiting for acknowledgements is never already M, a snooped read never leaves a line in M or E, a snooped invalidate always acknowledges and clears the line, a snooped Modified line always writes back, and the acknowledgement count never reaches the peer total while waiting. The bench's sweep takes every line through every start state and every event, then classifies the end state through two different probes. That sweep shows the full transition table. Directed scenarios show the acknowledgement counting across partial and ignored acknowledgements, and the lost-line race. Only these scenarios can show the ordering on the bus.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } loc_op_t;

    typedef enum logic [1:0] {
        CTL_IDLE    = 2'd0,
        CTL_FILL    = 2'd1,
        CTL_INVWAIT = 2'd2
    } ctl_st_t;

endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  line_st_t cur_st,
    input  logic     is_inval,
    output line_st_t nxt_st,
    output logic     give_wb,
    output logic     has_copy
);

    always_comb begin
        has_copy = (cur_st != ST_I);
        give_wb  = (cur_st == ST_M);
        nxt_st   = cur_st;
        if (is_inval) begin
            nxt_st = ST_I;
        end else begin
            unique case (cur_st)
                ST_M, ST_E: nxt_st = ST_S;
                ST_S:       nxt_st = ST_S;
                ST_I:       nxt_st = ST_I;
                default:    nxt_st = ST_I;
            endcase
        end
    end

endmodule

// File: rtl/mesi_ack_counter.sv
module mesi_ack_counter #(
    parameter  int NUM_PEERS = 3,
    localparam int CNT_W     = $clog2(2 * NUM_PEERS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 count_en,
    input  logic [NUM_PEERS-1:0] ack_in,
    output logic                 all_acked
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pop;
    logic [CNT_W-1:0] total;

    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_PEERS; i++) begin
            pop = pop + CNT_W'(ack_in[i]);
        end
        total     = cnt_q + pop;
        all_acked = count_en && (total >= CNT_W'(NUM_PEERS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= total;
        end
    end

    // R5: while waiting, the collected count stays below the peer total
    assert_ack_below_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (cnt_q < CNT_W'(NUM_PEERS)));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    parameter  int NUM_PEERS = 3,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 loc_valid,
    input  logic [1:0]           loc_op,
    input  logic [LINE_W-1:0]    loc_line,
    output logic                 loc_ready,
    output logic                 op_done,
    output logic                 wr_grant,
    output logic                 bus_fetch,
    output logic                 bus_inval,
    output logic                 bus_wb,
    output logic [LINE_W-1:0]    bus_line,
    input  logic                 fill_done,
    input  logic                 fill_shared,
    input  logic [NUM_PEERS-1:0] ack_in,
    input  logic                 snp_valid,
    input  logic                 snp_kind,
    input  logic [LINE_W-1:0]    snp_line,
    output logic                 snp_hit,
    output logic                 snp_wb,
    output logic                 snp_ack
);

    line_st_t          lines_q [NUM_LINES];
    line_st_t          lines_d [NUM_LINES];
    ctl_st_t           ctl_q, ctl_d;
    logic [LINE_W-1:0] pend_q, pend_d;
    logic              pend_wr_q, pend_wr_d;

    logic done_d, grant_d, fetch_d, inval_d, wb_d;
    logic ack_clear, all_acked;

    line_st_t snp_nxt;
    logic     snp_give_wb, snp_has_copy;

    loc_op_t  op;
    line_st_t cur_loc, cur_pend;
    logic     accept, snoop_kills_pend;

    mesi_snoop_resp u_snoop (
        .cur_st   (lines_q[snp_line]),
        .is_inval (snp_kind),
        .nxt_st   (snp_nxt),
        .give_wb  (snp_give_wb),
        .has_copy (snp_has_copy)
    );

    mesi_ack_counter #(.NUM_PEERS(NUM_PEERS)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ack_clear),
        .count_en  (ctl_q == CTL_INVWAIT),
        .ack_in    (ack_in),
        .all_acked (all_acked)
    );

    assign loc_ready        = (ctl_q == CTL_IDLE) && !snp_valid;
    assign accept           = loc_valid && loc_ready;
    assign op               = loc_op_t'(loc_op);
    assign cur_loc          = lines_q[loc_line];
    assign cur_pend         = lines_q[pend_q];
    assign snoop_kills_pend = snp_valid && snp_kind && (snp_line == pend_q);

    // next-state process: per-line table plus local controller
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) lines_d[i] = lines_q[i];
        if (snp_valid) lines_d[snp_line] = snp_nxt;
        ctl_d     = ctl_q;
        pend_d    = pend_q;
        pend_wr_d = pend_wr_q;
        done_d    = 1'b0;
        grant_d   = 1'b0;
        fetch_d   = 1'b0;
        inval_d   = 1'b0;
        wb_d      = 1'b0;
        ack_clear = 1'b0;

        unique case (ctl_q)
            CTL_IDLE: begin
                if (accept && op != OP_NONE) begin
                    pend_d    = loc_line;
                    pend_wr_d = (op == OP_WRITE);
                    unique case (op)
                        OP_READ: begin
                            if (cur_loc == ST_I) begin
                                fetch_d = 1'b1;
                                ctl_d   = CTL_FILL;
                            end else begin
                                done_d = 1'b1;
                            end
                        end
                        OP_WRITE: begin
                            unique case (cur_loc)
                                ST_M, ST_E: begin
                                    lines_d[loc_line] = ST_M;
                                    grant_d = 1'b1;
                                    done_d  = 1'b1;
                                end
                                ST_S: begin
                                    inval_d   = 1'b1;
                                    ack_clear = 1'b1;
                                    ctl_d     = CTL_INVWAIT;
                                end
                                default: begin
                                    fetch_d = 1'b1;
                                    ctl_d   = CTL_FILL;
                                end
                            endcase
                        end
                        default: begin
                            wb_d = (cur_loc == ST_M);
                            lines_d[loc_line] = ST_I;
                            done_d = 1'b1;
                        end
                    endcase
                end
            end
            CTL_FILL: begin
                if (fill_done) begin
                    if (!pend_wr_q) begin
                        lines_d[pend_q] = fill_shared ? ST_S : ST_E;
                        done_d = 1'b1;
                        ctl_d  = CTL_IDLE;
                    end else if (!fill_shared) begin
                        lines_d[pend_q] = ST_M;
                        grant_d = 1'b1;
                        done_d  = 1'b1;
                        ctl_d   = CTL_IDLE;
                    end else begin
                        lines_d[pend_q] = ST_S;
                        inval_d   = 1'b1;
                        ack_clear = 1'b1;
                        ctl_d     = CTL_INVWAIT;
                    end
                end
            end
            CTL_INVWAIT: begin
                if (all_acked) begin
                    if (cur_pend == ST_S && !snoop_kills_pend) begin
                        lines_d[pend_q] = ST_M;
                        grant_d = 1'b1;
                        done_d  = 1'b1;
                        ctl_d   = CTL_IDLE;
                    end else begin
                        fetch_d = 1'b1;
                        ctl_d   = CTL_FILL;
                    end
                end
            end
            default: ctl_d = CTL_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) lines_q[i] <= ST_I;
            ctl_q     <= CTL_IDLE;
            pend_q    <= '0;
            pend_wr_q <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) lines_q[i] <= lines_d[i];
            ctl_q     <= ctl_d;
            pend_q    <= pend_d;
            pend_wr_q <= pend_wr_d;
        end
    end

    // output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_done   <= 1'b0;
            wr_grant  <= 1'b0;
            bus_fetch <= 1'b0;
            bus_inval <= 1'b0;
            bus_wb    <= 1'b0;
            bus_line  <= '0;
            snp_hit   <= 1'b0;
            snp_wb    <= 1'b0;
            snp_ack   <= 1'b0;
        end else begin
            op_done   <= done_d;
            wr_grant  <= grant_d;
            bus_fetch <= fetch_d;
            bus_inval <= inval_d;
            bus_wb    <= wb_d;
            bus_line  <= pend_d;
            snp_hit   <= snp_valid && snp_has_copy;
            snp_wb    <= snp_valid && snp_give_wb;
            snp_ack   <= snp_valid && snp_kind;
        end
    end

    // R4 / R5: a granted write always finds its line Modified
    assert_grant_modified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> (lines_q[bus_line] == ST_M));

    // R5: no upgrade to Modified before the acknowledgements are in
    assert_wait_not_modified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q == CTL_INVWAIT) |-> (lines_q[pend_q] != ST_M));

    // R9: a snooped Modified line is written back
    assert_snoop_m_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && lines_q[snp_line] == ST_M) |=> snp_wb);

    // R9: a snooped read never leaves an owned copy behind
    assert_snoop_read_demotes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_kind && !(ctl_q == CTL_FILL && fill_done && pend_q == snp_line))
        |=> (lines_q[$past(snp_line)] == ST_S || lines_q[$past(snp_line)] == ST_I));

    // R10: a snooped invalidate acknowledges and clears the line
    assert_snoop_inval_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_kind && !(ctl_q == CTL_FILL && fill_done && pend_q == snp_line))
        |=> (snp_ack && lines_q[$past(snp_line)] == ST_I));

    // R11: nothing is accepted while a snoop is presented
    assert_snoop_blocks_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !loc_ready);

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int NP = 3;
    localparam int LW = 2;
    // bench state codes
    localparam int SI = 0, SS = 1, SE = 2, SM = 3;

    logic clk = 0, rst_n = 0;
    logic loc_valid = 0; logic [1:0] loc_op = 0; logic [LW-1:0] loc_line = 0;
    logic loc_ready, op_done, wr_grant, bus_fetch, bus_inval, bus_wb;
    logic [LW-1:0] bus_line;
    logic fill_done = 0, fill_shared = 0;
    logic [NP-1:0] ack_in = 0;
    logic snp_valid = 0, snp_kind = 0; logic [LW-1:0] snp_line = 0;
    logic snp_hit, snp_wb, snp_ack;

    int checks = 0, fails = 0;
    bit finished = 0;

    mesi_line_ctrl #(.NUM_LINES(NL), .NUM_PEERS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_op(loc_op),
        .loc_line(loc_line), .loc_ready(loc_ready), .op_done(op_done),
        .wr_grant(wr_grant), .bus_fetch(bus_fetch), .bus_inval(bus_inval),
        .bus_wb(bus_wb), .bus_line(bus_line), .fill_done(fill_done),
        .fill_shared(fill_shared), .ack_in(ack_in), .snp_valid(snp_valid),
        .snp_kind(snp_kind), .snp_line(snp_line), .snp_hit(snp_hit),
        .snp_wb(snp_wb), .snp_ack(snp_ack));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // path: 0 granted/done at once, 1 invalidate wait, 2 fetch
    task automatic local_op(input int op, input int line, input bit shared,
                            output int path, output bit wb, output bit grant);
        loc_valid = 1; loc_op = 2'(op); loc_line = LW'(line);
        step();
        loc_valid = 0;
        wb = bus_wb; path = 0;
        if (bus_fetch || bus_inval) chk("R3 bus_line", int'(bus_line), line);
        if (bus_fetch) begin
            path = 2;
            fill_done = 1; fill_shared = shared;
            step();
            fill_done = 0;
            if (bus_inval) begin
                ack_in = '1; step(); ack_in = 0;
            end
        end else if (bus_inval) begin
            path = 1;
            ack_in = '1; step(); ack_in = 0;
        end
        grant = wr_grant;
        if (op != 3) chk("R2 op_done", int'(op_done), 1);
    endtask

    task automatic snoop(input bit kind, input int line, output bit hit, output bit wb, output bit ack);
        snp_valid = 1; snp_kind = kind; snp_line = LW'(line);
        step();
        snp_valid = 0;
        hit = snp_hit; wb = snp_wb; ack = snp_ack;
    endtask

    task automatic setup(input int line, input int st);
        int p; bit w, g;
        local_op(2, line, 0, p, w, g);
        if (st == SE || st == SM) local_op(0, line, 0, p, w, g);
        if (st == SS) local_op(0, line, 1, p, w, g);
        if (st == SM) local_op(1, line, 0, p, w, g);
    endtask

    // probe A (snoop read): 2 M, 1 E or S, 0 I
    task automatic probe_a(input int line, output int cls);
        bit h, w, a;
        snoop(0, line, h, w, a);
        cls = w ? 2 : (h ? 1 : 0);
    endtask

    // probe B (local write): 0 M or E, 1 S, 2 I
    task automatic probe_b(input int line, output int cls);
        bit w, g;
        local_op(1, line, 0, cls, w, g);
    endtask

    function automatic int exp_a(input int s);
        return (s == SM) ? 2 : ((s == SI) ? 0 : 1);
    endfunction
    function automatic int exp_b(input int s);
        return (s == SS) ? 1 : ((s == SI) ? 2 : 0);
    endfunction

    function automatic int next_st(input int s, input int ev);
        case (ev)
            0: return (s == SI) ? SE : s;
            1: return (s == SI) ? SS : s;
            2: return SM;
            3: return SI;
            4: return (s == SM || s == SE) ? SS : s;
            default: return SI;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int p, cls; bit w, g, h, a;
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 loc_ready", int'(loc_ready), 1);
        chk("R1 pulses", int'({op_done, wr_grant, bus_fetch, bus_inval, bus_wb, snp_hit, snp_wb, snp_ack}), 0);
        for (int l = 0; l < NL; l++) begin
            probe_a(l, cls);
            chk("R1 line invalid", cls, 0);
        end

        // transition table sweep
        for (int l = 0; l < NL; l++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ev = 0; ev < 6; ev++) begin
                    for (int pr = 0; pr < 2; pr++) begin
                        setup(l, s);
                        case (ev)
                            0, 1: begin
                                local_op(0, l, ev[0], p, w, g);
                                chk(s == SI ? "R3 read miss fetch" : "R2 read hit quiet", p, s == SI ? 2 : 0);
                            end
                            2: begin
                                local_op(1, l, 1, p, w, g);
                                chk(s == SI ? "R6 write miss path" : (s == SS ? "R5 shared write path" : "R4 silent upgrade"),
                                    p, s == SI ? 2 : (s == SS ? 1 : 0));
                                chk("R4 wr_grant", int'(g), 1);
                            end
                            3: begin
                                local_op(2, l, 0, p, w, g);
                                chk("R8 evict writeback", int'(w), int'(s == SM));
                            end
                            default: begin
                                snoop(ev == 5, l, h, w, a);
                                chk(ev == 5 ? "R10 snoop hit" : "R9 snoop hit", int'(h), int'(s != SI));
                                chk(ev == 5 ? "R10 snoop writeback" : "R9 snoop writeback", int'(w), int'(s == SM));
                                chk(ev == 5 ? "R10 snoop ack" : "R9 snoop no ack", int'(a), int'(ev == 5));
                            end
                        endcase
                        if (pr == 0) begin
                            probe_a(l, cls);
                            chk("R9 next state (probe A)", cls, exp_a(next_st(s, ev)));
                        end else begin
                            probe_b(l, cls);
                            chk("R4 next state (probe B)", cls, exp_b(next_st(s, ev)));
                        end
                    end
                end
            end
        end

        // R5 partial and ignored acknowledgements
        setup(1, SS);
        ack_in = '1; step(); ack_in = 0;
        loc_valid = 1; loc_op = 2'd1; loc_line = 2'd1;
        step();
        loc_valid = 0;
        chk("R5 inval issued", int'(bus_inval), 1);
        chk("R5 no early grant", int'(wr_grant), 0);
        for (int k = 0; k < NP - 1; k++) begin
            ack_in = NP'(1) << k; step(); ack_in = 0;
            chk("R5 partial acks no grant", int'(wr_grant), 0);
        end
        ack_in = NP'(1) << (NP - 1); step(); ack_in = 0;
        chk("R5 grant after last ack", int'(wr_grant), 1);
        probe_a(1, cls);
        chk("R5 line modified", cls, 2);

        // R7 line lost while waiting
        setup(2, SS);
        loc_valid = 1; loc_op = 2'd1; loc_line = 2'd2;
        step();
        loc_valid = 0;
        chk("R7 inval issued", int'(bus_inval), 1);
        chk("R11 busy not ready", int'(loc_ready), 0);
        snoop(1, 2, h, w, a);
        chk("R7 snoop acked", int'(a), 1);
        ack_in = '1; step(); ack_in = 0;
        chk("R7 refetch", int'(bus_fetch), 1);
        chk("R7 no grant", int'(wr_grant), 0);
        fill_done = 1; fill_shared = 0; step(); fill_done = 0;
        chk("R7 grant after fill", int'(wr_grant), 1);

        // R11 local request refused during a snoop
        setup(0, SI);
        snp_valid = 1; snp_kind = 0; snp_line = 0;
        loc_valid = 1; loc_op = 2'd0; loc_line = 0;
        #1;
        chk("R11 loc_ready low", int'(loc_ready), 0);
        step();
        snp_valid = 0; loc_valid = 0;
        chk("R11 no fetch", int'(bus_fetch), 0);
        chk("R11 no done", int'(op_done), 0);

        // R12 no-operation code
        setup(3, SM);
        local_op(3, 3, 0, p, w, g);
        chk("R12 no done", int'(op_done), 0);
        chk("R12 no bus", int'({bus_fetch, bus_inval, bus_wb}), 0);
        probe_a(3, cls);
        chk("R12 state kept", cls, 2);

        // R10 other lines untouched
        setup(0, SM);
        setup(1, SS);
        snoop(1, 1, h, w, a);
        probe_a(0, cls);
        chk("R10 other line kept", cls, 2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule